// File: doc/BRIEF.md
# Time-Shared Four-Digit Hex Display Scanner

This block drives four seven-segment digits that share one set of segment wires. Each digit gets a 4-bit hexadecimal value and a decimal-point request. The block turns each value into a segment glyph. It then shows the digits one after another, so the eye sees all four lit at once.

A free-running refresh counter runs the scan. Its two most significant bits name the current digit. A one-hot anode output enables that digit, and the shared segment bus carries that digit's glyph. Segment lines are active-low and anode lines are active-high. Both outputs come from registers, so what appears at the pins reflects the inputs and counter as they were sampled at the previous clock edge. The block has no stream data path, so all of its pins are plain level signals with no valid/ready handshake.

Top module: `seg_scan_top`

## Requirements
- R1: `seg_n` is active-low: a 0 lights a segment. Bit 0 is segment a, bit 1 is b, and so on up to bit 6 for g. Bit 7 is the decimal point.
- R2: The value on `seg_n[6:0]` for each nibble, written as an 8-bit hex number with the dot dark, is: 0=C0, 1=F9, 2=A4, 3=B0, 4=99, 5=92, 6=82, 7=F8, 8=80, 9=90, A=88, b=83, C=C6, d=A1, E=86, F=8E.
- R3: `seg_n[7]` is the inverse of the shown digit's bit in `dp_in`. A 1 in `dp_in[i]` lights the dot of digit i.
- R4: Once reset is released, `anode` always has exactly one bit set. That bit is high, and it enables the matching digit.
- R5: Digit i's nibble sits in `hex_in[4i+3:4i]`. When `anode[i]` is set, `seg_n` carries digit i's glyph. The enabled digit steps through 0, 1, 2, 3 and then back to 0.
- R6: Each digit stays enabled for 2^(CNT_W-2) clock cycles before the scan moves on. With CNT_W=18 that is 65536 cycles.
- R7: While reset is high, and on the first cycle after it, the refresh counter is zero, `anode` is 0001 and `seg_n` is FF (everything dark).
- R8: The outputs are registered. A change on `hex_in` or `dp_in` appears on `seg_n` at the first clock edge after the change, as long as that digit is the one being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hex_in | input | 16 | Four hex nibbles; digit i in bits 4i+3..4i |
| dp_in | input | 4 | Decimal-point request per digit, active high |
| seg_n | output | 8 | Shared segment bus, active-low: {dp, g..a} |
| anode | output | 4 | One-hot digit enable, active high |

## Verification
A wrong refresh count shows at the ports as an anode slot that ends too early or too late. This is visible by the end of the second full slot after reset. A broken digit index or a broken one-hot decode shows up as a wrong or extra anode bit, or as a glyph paired with the wrong digit, on the very next clock edge. The bench predicts every output cycle from the requirements, so an error in a glyph or in dot polarity is caught the first time that nibble or dot is shown.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int NUM_DIG   = 4;
  localparam int DIG_IDX_W = $clog2(NUM_DIG);
  localparam int NIB_W     = 4;
  localparam int SEG_W     = 8;

  typedef logic [NIB_W-1:0] nibble_t;
  typedef logic [SEG_W-1:0] segbus_t;

  // active-low glyph for segments g..a (bit 0 = a)
  function automatic logic [6:0] glyph_low(input nibble_t v);
    logic [6:0] on;
    case (v)
      4'h0: on = 7'h3F;
      4'h1: on = 7'h06;
      4'h2: on = 7'h5B;
      4'h3: on = 7'h4F;
      4'h4: on = 7'h66;
      4'h5: on = 7'h6D;
      4'h6: on = 7'h7D;
      4'h7: on = 7'h07;
      4'h8: on = 7'h7F;
      4'h9: on = 7'h6F;
      4'hA: on = 7'h77;
      4'hB: on = 7'h7C;
      4'hC: on = 7'h39;
      4'hD: on = 7'h5E;
      4'hE: on = 7'h79;
      default: on = 7'h71;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/hex_glyph_dec.sv
module hex_glyph_dec
  import seg_scan_pkg::*;
(
  input  nibble_t value,
  input  logic    dot_req,
  output segbus_t pattern_n
);
  always_comb begin
    pattern_n[6:0] = glyph_low(value);
    pattern_n[7]   = ~dot_req;
  end
endmodule

// File: rtl/scan_timer.sv
module scan_timer
  import seg_scan_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [DIG_IDX_W-1:0] dig_idx,
  output logic [NUM_DIG-1:0]   dig_onehot
);
  logic [CNT_W-1:0] refresh_q;

  always_ff @(posedge clk) begin
    if (rst) refresh_q <= '0;
    else     refresh_q <= refresh_q + 1'b1;
  end

  assign dig_idx = refresh_q[CNT_W-1 -: DIG_IDX_W];

  for (genvar i = 0; i < NUM_DIG; i++) begin : g_sel
    assign dig_onehot[i] = (dig_idx == DIG_IDX_W'(i));
  end
endmodule

// File: rtl/digit_pick.sv
module digit_pick
  import seg_scan_pkg::*;
(
  input  segbus_t [NUM_DIG-1:0]  patterns,
  input  logic [DIG_IDX_W-1:0]   sel,
  output segbus_t                chosen
);
  always_comb begin
    chosen = '1;
    for (int i = 0; i < NUM_DIG; i++) begin
      if (sel == DIG_IDX_W'(i)) chosen = patterns[i];
    end
  end
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import seg_scan_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_DIG*NIB_W-1:0] hex_in,
  input  logic [NUM_DIG-1:0]       dp_in,
  output logic [SEG_W-1:0]         seg_n,
  output logic [NUM_DIG-1:0]       anode
);
  segbus_t [NUM_DIG-1:0] patt;
  segbus_t               picked;
  logic [DIG_IDX_W-1:0]  idx;
  logic [NUM_DIG-1:0]    onehot;

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_dec
    hex_glyph_dec u_dec (
      .value     (hex_in[d*NIB_W +: NIB_W]),
      .dot_req   (dp_in[d]),
      .pattern_n (patt[d])
    );
  end

  scan_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .dig_idx    (idx),
    .dig_onehot (onehot)
  );

  digit_pick u_pick (
    .patterns (patt),
    .sel      (idx),
    .chosen   (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n <= '1;
      anode <= NUM_DIG'(1);
    end else begin
      seg_n <= picked;
      anode <= onehot;
    end
  end
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
  parameter int CNT_W = 18
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] dp_in,
  input logic [7:0] seg_n,
  input logic [3:0] anode
);
  localparam int HOLD = 1 << (CNT_W - 2);

  logic             rst_d;
  logic [3:0]       an_d;
  logic [CNT_W-1:0] run;
  logic             seen;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    an_d  <= anode;
    if (rst) begin
      run  <= '0;
      seen <= 1'b0;
    end else if (anode != an_d) begin
      run  <= CNT_W'(1);
      seen <= 1'b1;
    end else begin
      run  <= run + 1'b1;
    end
  end

  // R7
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      reset_state_chk: assert (seg_n == 8'hFF && anode == 4'b0001)
        else $error("reset state wrong");
    end
  end

  // R4
  onehot_anode_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(anode) == 1);

  // R5
  rotate_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && anode != $past(anode)) |->
      anode == {$past(anode[2:0]), $past(anode[3])});

  // R3
  dot_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> seg_n[7] == ~|($past(dp_in) & anode));

  // R6
  dwell_len_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && anode != an_d) |-> run == CNT_W'(HOLD));
endmodule

bind seg_scan_top seg_scan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .dp_in (dp_in),
  .seg_n (seg_n),
  .anode (anode)
);

// File: tb/sim_seg_scan_top.sv
`timescale 1ns/1ps
module sim_seg_scan_top;
  localparam int CW   = 6;
  localparam int HOLD = 1 << (CW - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] hex_in = '0;
  logic [3:0]  dp_in = '0;
  logic [7:0]  seg_n;
  logic [3:0]  anode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic       r;
    logic [7:0] seg;
    logic [3:0] an;
  } exp_t;
  exp_t q[$];
  int   m_cnt = 0;

  always #2.5 clk = ~clk;

  seg_scan_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .hex_in(hex_in), .dp_in(dp_in),
    .seg_n(seg_n), .anode(anode)
  );

  // glyph values straight from R2 (dot dark)
  function automatic logic [7:0] ref_glyph(input logic [3:0] v);
    case (v)
      4'h0: return 8'hC0; 4'h1: return 8'hF9; 4'h2: return 8'hA4;
      4'h3: return 8'hB0; 4'h4: return 8'h99; 4'h5: return 8'h92;
      4'h6: return 8'h82; 4'h7: return 8'hF8; 4'h8: return 8'h80;
      4'h9: return 8'h90; 4'hA: return 8'h88; 4'hB: return 8'h83;
      4'hC: return 8'hC6; 4'hD: return 8'hA1; 4'hE: return 8'h86;
      default: return 8'h8E;
    endcase
  endfunction

  // driver: one expected item per coming posedge, inputs stable from a negedge
  task automatic drive(input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      if (rst) begin
        e.r = 1'b1; e.seg = 8'hFF; e.an = 4'b0001;
        m_cnt = 0;
      end else begin
        int idx;
        idx = (m_cnt >> (CW - 2)) & 3;
        e.r = 1'b0;
        e.an = 4'b0001 << idx;
        e.seg = ref_glyph(hex_in[idx*4 +: 4]);
        e.seg[7] = ~dp_in[idx];
        m_cnt = (m_cnt + 1) % (1 << CW);
      end
      q.push_back(e);
      @(negedge clk);
    end
  endtask

  // monitor
  logic [3:0] prev_an = 4'b0001;
  int  run = 0;
  bit  seen = 1'b0;
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.r) begin
        checks++;
        if (seg_n !== 8'hFF || anode !== 4'b0001) begin
          errors++;
          $display("FAIL R7 reset: seg=%h an=%b expected seg=ff an=0001", seg_n, anode);
        end
        seen = 1'b0; run = 0; prev_an = 4'b0001;
      end else begin
        checks++;
        if (seg_n[6:0] !== e.seg[6:0]) begin  // R1 R2 R8
          errors++;
          $display("FAIL R2 glyph: seg=%h expected %h", seg_n[6:0], e.seg[6:0]);
        end
        checks++;
        if (seg_n[7] !== e.seg[7]) begin
          errors++;
          $display("FAIL R3 dot: got %b expected %b", seg_n[7], e.seg[7]);
        end
        checks++;
        if (anode !== e.an || $countones(anode) != 1) begin  // R4
          errors++;
          $display("FAIL R5 anode: got %b expected %b", anode, e.an);
        end
        if (anode !== prev_an) begin
          if (seen) begin
            checks++;
            if (run != HOLD) begin
              errors++;
              $display("FAIL R6 dwell: got %0d expected %0d", run, HOLD);
            end
          end
          seen = 1'b1; run = 1;
        end else begin
          run++;
        end
        prev_an = anode;
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(3);
    // R5 distinct digits, alternating dots
    rst = 1'b0; hex_in = 16'h3210; dp_in = 4'b0101;
    drive(4 * HOLD + 8);
    // R2 every nibble on every digit
    for (int v = 0; v < 16; v++) begin
      hex_in = {4{v[3:0]}};
      dp_in  = v[3:0];
      drive(HOLD);
    end
    // R8 change mid-slot
    hex_in = 16'hA5C7; dp_in = 4'b1000;
    drive(HOLD / 2);
    hex_in = 16'h7E1B; dp_in = 4'b0110;
    drive(3 * HOLD);
    // R7 reset mid-scan
    rst = 1'b1;
    drive(2);
    rst = 1'b0; hex_in = 16'hFDB9; dp_in = 4'b1111;
    drive(4 * HOLD + 4);
    @(posedge clk); #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule